// File: doc/BRIEF.md
# Single-Cycle Execution Datapath

This block is the register-transfer half of a 32-bit single-cycle processor core with instruction fetch left outside. It takes one instruction word and a set of already-decoded control lines each cycle. It reads two source registers and forms the second ALU operand from either a register or an extended 16-bit immediate. It computes an add, subtract or OR, optionally reads or writes a 256-word data memory, and writes a result back to the register file on the rising clock edge.

Every routing choice is made by a single select line with fixed polarity, so a separate decoder drives the datapath by setting a handful of bits. The block returns a register-equality flag that the branch logic uses. It also exposes the ALU result and the write-back value so that the surrounding core can observe each instruction's effect.

Top module: `exec_datapath`

## Requirements
- R1: After reset, all 32 registers and all 256 memory words hold zero, so with rs=rt=0 the flag `equal` is 1 and `alu_result` is 0.
- R2: The instruction word is split as rs=[25:21], rt=[20:16], rd=[15:11] and imm16=[15:0]; bits [31:26] have no effect.
- R3: With `reg_dst`=0 the write-back goes to register rt; with `reg_dst`=1 it goes to register rd.
- R4: With `alu_src`=0 the ALU second operand is register rt's value; with `alu_src`=1 it is the extended immediate.
- R5: With `mem_to_reg`=0 the write-back value `wb_data` is the ALU result; with `mem_to_reg`=1 it is the data-memory word read at the ALU result address.
- R6: With `ext_sign`=1 imm16 is sign-extended to 32 bits; with `ext_sign`=0 it is zero-extended.
- R7: `alu_op` encoding: 2'b00 add, 2'b01 subtract (A minus B), 2'b10 bitwise OR, and 2'b11 adds.
- R8: When `mem_wr`=1, the memory word indexed by the ALU result is written at the rising edge with register rt's value; with `mem_wr`=0 memory is unchanged.
- R9: `equal` is 1 exactly when register rs's value equals register rt's value.
- R10: Register 0 always reads zero; a write addressed to it has no effect.
- R11: Register writes occur at the rising edge only when `reg_wr`=1, and they become visible on the read ports right after that edge; register reads are combinational.
- R12: The memory word index is ALU result bits [9:2], so addresses that differ only outside those bits reach the same word (0x400 aliases 0x000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| reg_dst | input | 1 | Destination select: 0 rt, 1 rd |
| alu_src | input | 1 | Operand B select: 0 register, 1 immediate |
| mem_to_reg | input | 1 | Write-back select: 0 ALU, 1 memory |
| ext_sign | input | 1 | Immediate extension: 1 sign, 0 zero |
| alu_op | input | 2 | ALU function code |
| reg_wr | input | 1 | Register file write enable |
| mem_wr | input | 1 | Data memory write enable |
| equal | output | 1 | rs value equals rt value |
| alu_result | output | 32 | ALU output |
| wb_data | output | 32 | Value presented for register write-back |

## Verification
Directed instruction sequences first load registers through immediates of both signs under both extension modes. These sequences separate zero extension from sign extension and separate the rt destination from the rd destination. They then run register-register add, subtract, OR and the spare ALU code, stores with the enable both on and off, loads that hit aliased addresses, writes aimed at register 0, and equality compares of equal and unequal pairs. A long stretch of random instruction words and control settings then exercises all select combinations together against the bench's own register and memory model. This exposes any swapped mux polarity, a wrong field slice or a lost write.

// File: rtl/dp_pkg.sv
package dp_pkg;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_OR   = 2'b10,
        ALU_ADD2 = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic    reg_dst;
        logic    alu_src;
        logic    mem_to_reg;
        logic    ext_sign;
        alu_op_e alu_op;
        logic    reg_wr;
        logic    mem_wr;
    } dp_ctrl_t;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int WIDTH = 32,
    parameter int NREGS = 32,
    localparam int AW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata
);
    logic [WIDTH-1:0] regs_q [NREGS];
    logic [WIDTH-1:0] regs_d [NREGS];
    logic             armed_q;

    always_comb begin
        for (int i = 0; i < NREGS; i++) regs_d[i] = regs_q[i];
        if (we && waddr != '0) regs_d[waddr] = wdata;
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
            armed_q <= 1'b0;
        end else begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
            armed_q <= 1'b1;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

    // Written value is readable on the next cycle
    assert_write_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(we) && $past(waddr) != '0 && raddr_a == $past(waddr))
        |-> rdata_a == $past(wdata));

    // Register zero stays zero after a write aimed at it
    assert_zero_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(we) && $past(waddr) == '0 && raddr_b == '0)
        |-> rdata_b == '0);
endmodule

// File: rtl/dp_extend.sv
module dp_extend #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  imm,
    input  logic             sign_mode,
    output logic [OUT_W-1:0] ext
);
    localparam int PAD = OUT_W - IN_W;

    always_comb begin
        ext = {{PAD{sign_mode & imm[IN_W-1]}}, imm};
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/dp_dmem.sv
module dp_dmem #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 256,
    localparam int IW = $clog2(DEPTH),
    localparam int LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] addr,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [IW-1:0]    idx;
    logic             armed_q;
    logic             unused_addr_bits;

    assign idx = addr[IW+LSB-1:LSB];
    assign unused_addr_bits = ^{addr[WIDTH-1:IW+LSB], addr[LSB-1:0]};

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            armed_q <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
            armed_q <= 1'b1;
        end
    end

    assign rdata = mem_q[idx];

    // Stored word reads back at the same index on the next cycle
    assert_store_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(we) && idx == $past(idx)) |-> rdata == $past(wdata));
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
    import dp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr,
    input  logic        reg_dst,
    input  logic        alu_src,
    input  logic        mem_to_reg,
    input  logic        ext_sign,
    input  logic [1:0]  alu_op,
    input  logic        reg_wr,
    input  logic        mem_wr,
    output logic        equal,
    output logic [31:0] alu_result,
    output logic [31:0] wb_data
);
    localparam int NREGS = 32;
    localparam int DEPTH = 256;
    localparam int RAW   = $clog2(NREGS);
    localparam int IMM_W = 16;

    dp_ctrl_t         ctrl;
    logic [RAW-1:0]   rs, rt, rd, dst;
    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  bus_a, bus_b, imm_ext, opnd_b, mem_rd;
    logic             unused_opcode;

    assign ctrl = '{reg_dst: reg_dst, alu_src: alu_src, mem_to_reg: mem_to_reg,
                    ext_sign: ext_sign, alu_op: alu_op_e'(alu_op),
                    reg_wr: reg_wr, mem_wr: mem_wr};

    assign rs  = instr[25:21];
    assign rt  = instr[20:16];
    assign rd  = instr[15:11];
    assign imm = instr[15:0];
    assign unused_opcode = ^instr[31:26];

    assign dst = ctrl.reg_dst ? rd : rt;

    dp_regfile #(.WIDTH(XLEN), .NREGS(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .raddr_a(rs), .raddr_b(rt),
        .rdata_a(bus_a), .rdata_b(bus_b),
        .we(ctrl.reg_wr), .waddr(dst), .wdata(wb_data)
    );

    dp_extend #(.IN_W(IMM_W), .OUT_W(XLEN)) u_ext (
        .imm(imm), .sign_mode(ctrl.ext_sign), .ext(imm_ext)
    );

    assign opnd_b = ctrl.alu_src ? imm_ext : bus_b;

    dp_alu #(.WIDTH(XLEN)) u_alu (
        .a(bus_a), .b(opnd_b), .op(ctrl.alu_op), .y(alu_result)
    );

    // Subtraction result added back to operand B restores operand A
    assert_sub_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.alu_op == ALU_SUB) |-> (alu_result + opnd_b) == bus_a);

    dp_dmem #(.WIDTH(XLEN), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .addr(alu_result), .we(ctrl.mem_wr),
        .wdata(bus_b), .rdata(mem_rd)
    );

    assign wb_data = ctrl.mem_to_reg ? mem_rd : alu_result;
    assign equal   = (bus_a == bus_b);

    // With equal operands an immediate-free subtract yields zero
    assert_equal_sub_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (equal && !ctrl.alu_src && ctrl.alu_op == ALU_SUB) |-> alu_result == '0);
endmodule

// File: tb/exec_datapath_tb.sv
`timescale 1ns/1ps
module exec_datapath_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic        reg_dst, alu_src, mem_to_reg, ext_sign, reg_wr, mem_wr;
    logic [1:0]  alu_op;
    logic        equal;
    logic [31:0] alu_result, wb_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_regs [32];
    logic [31:0] m_mem  [256];

    always #4 clk = ~clk;

    exec_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .instr(instr),
        .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
        .ext_sign(ext_sign), .alu_op(alu_op), .reg_wr(reg_wr), .mem_wr(mem_wr),
        .equal(equal), .alu_result(alu_result), .wb_data(wb_data)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op6, input int s, input int t,
                                       input int d, input int lo);
        logic [31:0] w;
        w = {op6[5:0], s[4:0], t[4:0], 16'h0};
        w[15:0] = (d >= 0) ? {d[4:0], lo[10:0]} : lo[15:0];
        return w;
    endfunction

    // One instruction: drive, compare against model, advance model at the edge
    task automatic step(input string tag, input logic [31:0] iw,
                        input logic rdst, input logic asrc, input logic m2r,
                        input logic sx, input logic [1:0] op,
                        input logic rw, input logic mw);
        logic [31:0] a, b, ext, ob, y, md, wb;
        int dsti;
        @(negedge clk);
        instr = iw; reg_dst = rdst; alu_src = asrc; mem_to_reg = m2r;
        ext_sign = sx; alu_op = op; reg_wr = rw; mem_wr = mw;
        #1;
        a   = m_regs[iw[25:21]];
        b   = m_regs[iw[20:16]];
        ext = sx ? {{16{iw[15]}}, iw[15:0]} : {16'h0, iw[15:0]};
        ob  = asrc ? ext : b;
        case (op)
            2'b01:   y = a - ob;
            2'b10:   y = a | ob;
            default: y = a + ob;
        endcase
        md = m_mem[y[9:2]];
        wb = m2r ? md : y;
        check(tag, "equal", {31'b0, equal}, {31'b0, a == b});
        check(tag, "alu_result", alu_result, y);
        check(tag, "wb_data", wb_data, wb);
        @(posedge clk);
        dsti = rdst ? int'(iw[15:11]) : int'(iw[20:16]);
        if (rw && dsti != 0) m_regs[dsti] = wb;
        if (mw) m_mem[y[9:2]] = b;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) m_regs[i] = '0;
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        rst_n = 0; instr = '0; reg_dst = 0; alu_src = 0; mem_to_reg = 0;
        ext_sign = 0; alu_op = 0; reg_wr = 0; mem_wr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state: registers zero, memory zero
        step("R1", mk(0, 0, 0, 0, 0), 0, 0, 0, 0, 2'b00, 0, 0);
        step("R1", mk(0, 7, 9, 0, 16'h0040), 0, 1, 1, 0, 2'b00, 0, 0);

        // R4 R6 immediates of both kinds into rt (R3 rt destination)
        step("R4", mk(8, 0, 1, -1, 16'h0005), 0, 1, 0, 1, 2'b00, 1, 0);
        step("R6", mk(8, 0, 2, -1, 16'hFFFF), 0, 1, 0, 1, 2'b00, 1, 0);
        step("R6", mk(13, 0, 3, -1, 16'hFFFF), 0, 1, 0, 0, 2'b10, 1, 0);
        step("R6", mk(8, 0, 6, -1, 16'h8001), 0, 1, 0, 0, 2'b00, 1, 0);
        // R3 rd destination, R7 all ALU codes
        step("R3", mk(0, 1, 2, 4, 0), 1, 0, 0, 0, 2'b00, 1, 0);
        step("R7", mk(0, 1, 2, 5, 0), 1, 0, 0, 0, 2'b01, 1, 0);
        step("R7", mk(0, 3, 1, 7, 0), 1, 0, 0, 0, 2'b10, 1, 0);
        step("R7", mk(0, 6, 3, 8, 0), 1, 0, 0, 0, 2'b11, 1, 0);
        step("R3", mk(0, 4, 5, 0, 0), 0, 0, 0, 0, 2'b00, 0, 0);
        // R2 opcode bits have no effect
        step("R2", mk(63, 1, 3, 9, 0), 1, 0, 0, 0, 2'b00, 1, 0);
        step("R2", mk(0, 9, 0, 0, 0), 0, 0, 0, 0, 2'b00, 0, 0);
        // R10 writes to register 0 ignored
        step("R10", mk(8, 0, 0, -1, 16'h1234), 0, 1, 0, 1, 2'b00, 1, 0);
        step("R10", mk(0, 0, 0, 0, 0), 0, 0, 0, 0, 2'b00, 0, 0);
        // R11 reg_wr low leaves register unchanged
        step("R11", mk(8, 0, 10, -1, 16'h0777), 0, 1, 0, 1, 2'b00, 0, 0);
        step("R11", mk(0, 10, 0, 0, 0), 0, 0, 0, 0, 2'b00, 0, 0);
        // R8 store, store disabled, then R5 load back
        step("R8", mk(43, 1, 3, -1, 16'h0008), 0, 1, 0, 1, 2'b00, 0, 1);
        step("R8", mk(43, 1, 4, -1, 16'h000C), 0, 1, 0, 1, 2'b00, 0, 0);
        step("R5", mk(35, 1, 11, -1, 16'h0008), 0, 1, 1, 1, 2'b00, 1, 0);
        step("R5", mk(35, 1, 12, -1, 16'h000C), 0, 1, 1, 1, 2'b00, 1, 0);
        step("R5", mk(0, 11, 3, 0, 0), 0, 0, 0, 0, 2'b00, 0, 0);
        // R12 aliasing: store at 0x400, read at 0x000
        step("R12", mk(43, 0, 5, -1, 16'h0400), 0, 1, 0, 1, 2'b00, 0, 1);
        step("R12", mk(35, 0, 13, -1, 16'h0000), 0, 1, 1, 1, 2'b00, 1, 0);
        step("R12", mk(35, 0, 14, -1, 16'hFFFC), 0, 1, 1, 1, 2'b00, 1, 0);
        // R9 equality on equal and unequal pairs
        step("R9", mk(4, 1, 1, -1, 0), 0, 0, 0, 0, 2'b01, 0, 0);
        step("R9", mk(4, 1, 2, -1, 0), 0, 0, 0, 0, 2'b01, 0, 0);
        step("R9", mk(4, 13, 5, -1, 0), 0, 0, 0, 0, 2'b01, 0, 0);

        // R2 random instruction words and control combinations
        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            logic [7:0]  c;
            w = $urandom;
            c = 8'($urandom);
            if (c[7]) w[15:0] = {6'h0, w[9:0]};
            step("R2", w, c[0], c[1], c[2], c[3], c[5:4], c[6], c[7] & c[0]);
        end

        finish_run();
    end
endmodule